// File: doc/BRIEF.md
# Port Change-Detect Interrupt Controller

This block generates the interrupt request for a 16-bit general-purpose I/O expander organised as two 8-bit ports that are handled separately. For each port it holds a reference copy of the synchronized pin levels. Any pin set up as an input whose level now differs from its reference bit raises the interrupt. If every differing pin goes back to its reference level, the interrupt withdraws by itself. When the host reads a port, the serial front end pulses a read-acknowledge strobe together with the port index and an own-address match flag. On that strobe the block reloads the reference of that port only, and the pending change of that port no longer counts toward the interrupt.

The interrupt leaves the block as a pull-low enable for an open-drain line. While the enable is high the line is pulled low (interrupt active). While the enable is low the line is released and a pull-up takes it high. Pin levels cross into the clock domain through a synchronizer chain. A parameterizable delay line then sets a fixed latency from a pin edge to a valid interrupt. The reference copies are also driven out, because they are the data the front end returns on a read.

Top module: `pcd_int_ctrl`

## Requirements
- R1: A rising or falling level change on any input-mode pin sets `int_pull_o` high exactly SYNC_STAGES+VALID_DLY clock edges after the first edge that samples the new level, and not one edge earlier. A value of 1 on `int_pull_o` means the line is driven low.
- R2: If every differing input pin returns to its reference level, `int_pull_o` goes low again after the same latency as in R1.
- R3: A read strobe (`rd_ack_i`=1 with `rd_dev_match_i`=1) loads the reference of port `rd_port_i` with that port's synchronized pins at the strobe edge. The new value appears on `snap_o` (port p at bits p*8+7..p*8) one edge later. If no other port is pending, `int_pull_o` goes low VALID_DLY edges after the strobe edge.
- R4: A read of one port leaves the reference of the other port unchanged, and a change pending on the other port keeps `int_pull_o` high.
- R5: A pin with its `dir_in_i` bit at 0 (output) never causes the interrupt, whatever its level.
- R6: A strobe with `rd_dev_match_i`=0 changes no reference and does not clear the interrupt.
- R7: If a pin is switched from output to input (`dir_in_i` bit 0 to 1) while its level differs from its reference bit, `int_pull_o` goes high VALID_DLY edges after the edge that samples the new direction.
- R8: After the interrupt has been cleared by a read, a later change on an input pin asserts it again with the latency of R1.
- R9: A change that first shows at the synchronizer output in the same cycle as a read strobe for its port is taken into the reference and never raises `int_pull_o`.
- R10: After reset `int_pull_o` is low. Once SYNC_STAGES+1 edges have passed, each reference holds the pin levels that were stable through reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 16 | Raw pin levels, port p at bits p*8+7..p*8 |
| dir_in_i | input | 16 | Per-pin direction, 1 = input (compared), 0 = output (masked) |
| rd_ack_i | input | 1 | One-cycle pulse at the acknowledge before a read data byte |
| rd_dev_match_i | input | 1 | The current bus transfer addresses this device |
| rd_port_i | input | 1 | Index of the port being read |
| int_pull_o | output | 1 | Pull-low enable for the open-drain interrupt line |
| snap_o | output | 16 | Reference copies of both ports, same bit layout as pin_i |

## Verification
A wrong reference bit shows up on `snap_o` one edge after the strobe that loaded it. It also appears as a stuck or spurious `int_pull_o` within SYNC_STAGES+VALID_DLY edges of the next pin change. A fault in masking or in port selection shows as an interrupt that is asserted or released on the wrong cycle, so every expectation is tied to one exact edge count and is checked one cycle before that edge as well. The case where a change coincides with the strobe is aimed at the cycle in which the synchronizer output moves, to catch an off-by-one between capture and masking.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
    localparam int unsigned PCD_PORT_W    = 8;
    localparam int unsigned PCD_NUM_PORTS = 2;
    localparam int unsigned PCD_SYNC      = 2;
    localparam int unsigned PCD_VALID_DLY = 3;

    function automatic int unsigned pcd_idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic int unsigned pcd_cnt_w(input int unsigned maxval);
        return (maxval > 0) ? $clog2(maxval + 1) : 1;
    endfunction
endpackage

// File: rtl/pcd_sync.sv
module pcd_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_state_t;

    sync_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stg[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            s_d.stg[i] = s_q.stg[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sync_o = s_q.stg[STAGES-1];
endmodule

// File: rtl/pcd_port_track.sv
module pcd_port_track #(
    parameter int unsigned W     = 8,
    parameter int unsigned PRIME = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] pin_s_i,
    input  logic [W-1:0] dir_in_i,
    input  logic         cap_i,
    output logic [W-1:0] ref_o,
    output logic         chg_o
);
    localparam int unsigned CW = pcd_pkg::pcd_cnt_w(PRIME);

    typedef struct packed {
        logic [W-1:0]  ref_val;
        logic [CW-1:0] prime_cnt;
    } trk_state_t;

    trk_state_t t_d, t_q;
    logic       priming;
    logic [W-1:0] diff;

    assign priming = (t_q.prime_cnt != '0);

    always_comb begin
        t_d = t_q;
        if (priming) begin
            t_d.ref_val   = pin_s_i;
            t_d.prime_cnt = t_q.prime_cnt - 1'b1;
        end else if (cap_i) begin
            t_d.ref_val = pin_s_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            t_q.ref_val   <= '0;
            t_q.prime_cnt <= CW'(PRIME);
        end else begin
            t_q <= t_d;
        end
    end

    // Only input-mode pins take part in the comparison; the strobe masks the
    // cycle in which the reference is being reloaded.
    assign diff  = (pin_s_i ^ t_q.ref_val) & dir_in_i;
    assign chg_o = (|diff) && !cap_i && !priming;
    assign ref_o = t_q.ref_val;
endmodule

// File: rtl/pcd_valid_dly.sv
module pcd_valid_dly #(
    parameter int unsigned DLY = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic dly_o
);
    typedef struct packed {
        logic [DLY-1:0] pipe;
    } dly_state_t;

    dly_state_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        p_d.pipe[0] = raw_i;
        for (int i = 1; i < DLY; i++) begin
            p_d.pipe[i] = p_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign dly_o = p_q.pipe[DLY-1];
endmodule

// File: rtl/pcd_int_ctrl.sv
module pcd_int_ctrl #(
    parameter int unsigned PORT_W      = pcd_pkg::PCD_PORT_W,
    parameter int unsigned NUM_PORTS   = pcd_pkg::PCD_NUM_PORTS,
    parameter int unsigned SYNC_STAGES = pcd_pkg::PCD_SYNC,
    parameter int unsigned VALID_DLY   = pcd_pkg::PCD_VALID_DLY,
    localparam int unsigned TOT_W      = PORT_W * NUM_PORTS,
    localparam int unsigned IDX_W      = pcd_pkg::pcd_idx_w(NUM_PORTS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [TOT_W-1:0] pin_i,
    input  logic [TOT_W-1:0] dir_in_i,
    input  logic             rd_ack_i,
    input  logic             rd_dev_match_i,
    input  logic [IDX_W-1:0] rd_port_i,
    output logic             int_pull_o,
    output logic [TOT_W-1:0] snap_o
);
    localparam int unsigned PRIME_CYC = SYNC_STAGES + 1;

    logic [TOT_W-1:0]     pin_s;
    logic [NUM_PORTS-1:0] chg;
    logic [NUM_PORTS-1:0] cap;
    logic                 chg_any;

    pcd_sync #(
        .W      (TOT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (pin_i),
        .sync_o (pin_s)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(p);

        assign cap[p] = rd_ack_i && rd_dev_match_i && (rd_port_i == MY_IDX);

        pcd_port_track #(
            .W     (PORT_W),
            .PRIME (PRIME_CYC)
        ) u_trk (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .pin_s_i  (pin_s[p*PORT_W +: PORT_W]),
            .dir_in_i (dir_in_i[p*PORT_W +: PORT_W]),
            .cap_i    (cap[p]),
            .ref_o    (snap_o[p*PORT_W +: PORT_W]),
            .chg_o    (chg[p])
        );
    end

    assign chg_any = |chg;

    pcd_valid_dly #(
        .DLY (VALID_DLY)
    ) u_dly (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .raw_i  (chg_any),
        .dly_o  (int_pull_o)
    );
endmodule

// File: rtl/pcd_int_ctrl_chk.sv
module pcd_int_ctrl_chk #(
    parameter int unsigned PORT_W      = 8,
    parameter int unsigned NUM_PORTS   = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned VALID_DLY   = 3,
    localparam int unsigned TOT_W      = PORT_W * NUM_PORTS,
    localparam int unsigned IDX_W      = pcd_pkg::pcd_idx_w(NUM_PORTS)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rd_ack_i,
    input logic             rd_dev_match_i,
    input logic [IDX_W-1:0] rd_port_i,
    input logic [TOT_W-1:0] pin_s_i,
    input logic [TOT_W-1:0] snap_i,
    input logic             chg_any_i,
    input logic             int_pull_i
);
    localparam int unsigned SETTLE = SYNC_STAGES + 1;
    localparam int unsigned SW     = pcd_pkg::pcd_cnt_w(SETTLE);
    localparam int unsigned DW     = pcd_pkg::pcd_cnt_w(VALID_DLY);

    logic [SW-1:0] settle_q;
    logic [DW-1:0] busy_q, quiet_q;
    logic          settled;

    assign settled = (settle_q >= SW'(SETTLE));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            settle_q <= '0;
            busy_q   <= '0;
            quiet_q  <= '0;
        end else begin
            if (!settled) settle_q <= settle_q + 1'b1;
            if (chg_any_i) begin
                quiet_q <= '0;
                if (busy_q < DW'(VALID_DLY)) busy_q <= busy_q + 1'b1;
            end else begin
                busy_q <= '0;
                if (quiet_q < DW'(VALID_DLY)) quiet_q <= quiet_q + 1'b1;
            end
        end
    end

    p_int_follows_change_r1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_q >= DW'(VALID_DLY)) |-> int_pull_i);

    p_int_releases_r2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet_q >= DW'(VALID_DLY)) |-> !int_pull_i);

    p_foreign_ignored_r6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (settled && rd_ack_i && !rd_dev_match_i) |=> $stable(snap_i));

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(p);

        p_read_loads_ref_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (rd_ack_i && rd_dev_match_i && rd_port_i == MY_IDX)
            |=> snap_i[p*PORT_W +: PORT_W] == $past(pin_s_i[p*PORT_W +: PORT_W]));

        p_other_port_kept_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
            (settled && rd_ack_i && rd_dev_match_i && rd_port_i != MY_IDX)
            |=> $stable(snap_i[p*PORT_W +: PORT_W]));
    end
endmodule

bind pcd_int_ctrl pcd_int_ctrl_chk #(
    .PORT_W      (PORT_W),
    .NUM_PORTS   (NUM_PORTS),
    .SYNC_STAGES (SYNC_STAGES),
    .VALID_DLY   (VALID_DLY)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rd_ack_i       (rd_ack_i),
    .rd_dev_match_i (rd_dev_match_i),
    .rd_port_i      (rd_port_i),
    .pin_s_i        (pin_s),
    .snap_i         (snap_o),
    .chg_any_i      (chg_any),
    .int_pull_i     (int_pull_o)
);

// File: tb/pcd_int_ctrl_bench.sv
module pcd_int_ctrl_bench;
    localparam int SYNC = 2;
    localparam int DLY  = 3;
    localparam int LAT  = SYNC + DLY;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pins = 16'hA55A;
    logic [15:0] dir  = 16'hFFFF;
    logic        ack = 1'b0;
    logic        match = 1'b1;
    logic [0:0]  rport = 1'b0;
    logic        int_pull;
    logic [15:0] snap;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic        exp_int;
        logic [15:0] exp_snap;
        string       tag;
    } item_t;

    item_t sb[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pcd_int_ctrl #(
        .PORT_W      (8),
        .NUM_PORTS   (2),
        .SYNC_STAGES (SYNC),
        .VALID_DLY   (DLY)
    ) u_pcd_int_ctrl (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .pin_i          (pins),
        .dir_in_i       (dir),
        .rd_ack_i       (ack),
        .rd_dev_match_i (match),
        .rd_port_i      (rport),
        .int_pull_o     (int_pull),
        .snap_o         (snap)
    );

    // Driver side: queue an expectation 'delta' cycles from now.
    task automatic expect_at(input int delta, input logic e_int,
                             input logic [15:0] e_snap, input string tag);
        item_t it;
        it.due = cyc + delta;
        it.exp_int = e_int;
        it.exp_snap = e_snap;
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_port(input logic p, input logic m);
        rport = p;
        match = m;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        match = 1'b1;
    endtask

    // Monitor side: compare due items away from the active edge.
    always @(negedge clk) begin
        while (sb.size() != 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (int_pull !== it.exp_int) begin
                errors++;
                $display("FAIL %s int_pull cyc %0d actual %b expected %b",
                         it.tag, cyc, int_pull, it.exp_int);
            end
            checks++;
            if (snap !== it.exp_snap) begin
                errors++;
                $display("FAIL %s snap cyc %0d actual %h expected %h",
                         it.tag, cyc, snap, it.exp_snap);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        // R10: released interrupt, references hold the stable pins
        expect_at(0, 1'b0, 16'hA55A, "R10");
        drain();

        // R1: rising edge on port 0 bit 0
        pins = 16'hA55B;
        expect_at(LAT - 1, 1'b0, 16'hA55A, "R1");
        expect_at(LAT, 1'b1, 16'hA55A, "R1");
        drain();

        // R2: revert clears
        pins = 16'hA55A;
        expect_at(LAT - 1, 1'b1, 16'hA55A, "R2");
        expect_at(LAT, 1'b0, 16'hA55A, "R2");
        drain();

        // R1: falling edge on port 1 bit 15
        pins = 16'h255A;
        expect_at(LAT - 1, 1'b0, 16'hA55A, "R1");
        expect_at(LAT, 1'b1, 16'hA55A, "R1");
        drain();

        // R3: read port 1 reloads its reference and clears
        expect_at(1, 1'b1, 16'h255A, "R3");
        expect_at(DLY - 1, 1'b1, 16'h255A, "R3");
        expect_at(DLY, 1'b0, 16'h255A, "R3");
        read_port(1'b1, 1'b1);
        drain();

        // R8: new change detected after a read clear
        pins = 16'h255B;
        expect_at(LAT - 1, 1'b0, 16'h255A, "R8");
        expect_at(LAT, 1'b1, 16'h255A, "R8");
        drain();

        // R4: both ports pending, read port 0 only
        pins = 16'h355B;
        repeat (LAT + 1) @(negedge clk);
        expect_at(1, 1'b1, 16'h255B, "R4");
        expect_at(DLY + 2, 1'b1, 16'h255B, "R4");
        read_port(1'b0, 1'b1);
        drain();
        expect_at(1, 1'b1, 16'h355B, "R4");
        expect_at(DLY, 1'b0, 16'h355B, "R4");
        read_port(1'b1, 1'b1);
        drain();

        // R5: output pin toggling is masked
        dir = 16'hFFFE;
        pins = 16'h355A;
        expect_at(LAT + 2, 1'b0, 16'h355B, "R5");
        drain();

        // R7: switching the mismatching pin back to input raises the interrupt
        dir = 16'hFFFF;
        expect_at(DLY - 1, 1'b0, 16'h355B, "R7");
        expect_at(DLY, 1'b1, 16'h355B, "R7");
        drain();

        // R6: strobe for another device changes nothing
        expect_at(1, 1'b1, 16'h355B, "R6");
        expect_at(DLY + 2, 1'b1, 16'h355B, "R6");
        read_port(1'b0, 1'b0);
        drain();
        expect_at(1, 1'b1, 16'h355A, "R3");
        expect_at(DLY, 1'b0, 16'h355A, "R3");
        read_port(1'b0, 1'b1);
        drain();

        // R9: change reaching the synchronizer output with the strobe is absorbed
        pins = 16'h355E;
        repeat (SYNC) @(negedge clk);
        expect_at(0, 1'b0, 16'h355A, "R9");
        expect_at(1, 1'b0, 16'h355E, "R9");
        expect_at(DLY, 1'b0, 16'h355E, "R9");
        expect_at(LAT + 1, 1'b0, 16'h355E, "R9");
        read_port(1'b0, 1'b1);
        drain();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule